// File: doc/BRIEF.md
# Loadable Decimal Display Counter

This block holds one decimal digit and drives a seven-segment display from it. It runs from a fast board clock. A parameterised divider produces a one-cycle enable pulse every `DIV_RATIO` clocks, which slows the count to a rate a person can follow. The digit moves only on that pulse, either upward or downward, and by a step that can be selected. The step and the result are both reduced modulo ten, so the register always holds a legal BCD code.

Two controls override counting. An active-high clear input forces the digit to zero at once and keeps it there while the input stays high; it does not wait for a clock edge. A synchronous load copies a four-bit value into the digit on the next clock edge, whether or not the divider is pulsing at that moment, and a value above nine is reduced modulo ten before it is stored. The active-low chip reset returns both the digit and the divider phase to zero.

Top module: `bcd_disp_counter`

## Requirements
- R1: The divider pulses once every `DIV_RATIO` rising clock edges. With clear and load low, the digit changes only on the edge that ends a pulse cycle.
- R2: With `dir_i`=0 (up) the digit becomes (digit + step) mod 10, so from 9 with step 1 it becomes 0.
- R3: With `dir_i`=1 (down) the digit becomes (digit − step) mod 10, so from 0 with step 1 it becomes 9.
- R4: The step applied is `step_i` mod 10. Steps of 10 and 0 leave the digit unchanged on a pulse, and a step of 13 behaves as 3.
- R5: While `clr_i` is high the digit is 0. It goes to 0 without waiting for a clock edge, and neither load nor pulse changes it.
- R6: With `clr_i` low, `load_i` high loads the digit on the next rising edge even if no pulse is present, and it takes priority over counting.
- R7: The load value `load_val_i` is an unsigned nibble whose bit 3 is the most significant. A value of 10 to 15 is stored as value − 10.
- R8: `seg_o` is active high, with segment a on bit 0 through segment g on bit 6. The glyphs are 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F and 9=0x6F.
- R9: While `rst_ni` is low the digit is 0 and the divider phase is cleared. After release, the first pulse ends on the `DIV_RATIO`-th rising edge.
- R10: `digit_o` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast board clock |
| rst_ni | input | 1 | Asynchronous chip reset, active low |
| clr_i | input | 1 | Asynchronous level-sensitive digit clear, active high |
| load_i | input | 1 | Synchronous load strobe |
| load_val_i | input | 4 | Value to load, bit 3 MSB |
| dir_i | input | 1 | 0 counts up, 1 counts down |
| step_i | input | 4 | Step size, applied modulo 10 |
| digit_o | output | 4 | Current BCD digit |
| seg_o | output | 7 | Segment drive, bit 0 = a through bit 6 = g |

## Verification
The assertions assume that every control input other than `clr_i` is stable around the rising clock edge. They also assume that `clr_i` is a clean level with no glitches, so that the cycle after a load or a pulse can be predicted unless a clear arrives. The stimulus changes all inputs 2 ns after a rising edge and compares outputs 1 ns after the falling edge. Clear is raised at that same mid-cycle point, both to show that it acts at once and to test it against load and pulses held high across several edges.

// File: rtl/bcd_disp_pkg.sv
package bcd_disp_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned RADIX   = 10;

  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;
  typedef logic [DIGIT_W:0]   wide_t;

  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;

  // single fold; valid for inputs below 2*RADIX
  function automatic bcd_t fold_radix(wide_t v);
    if (v >= wide_t'(RADIX)) return bcd_t'(v - wide_t'(RADIX));
    return v[DIGIT_W-1:0];
  endfunction

  // active high, bit0 = a ... bit6 = g
  function automatic seg_t glyph(bcd_t d);
    case (d)
      4'd0:    return 7'h3F;
      4'd1:    return 7'h06;
      4'd2:    return 7'h5B;
      4'd3:    return 7'h4F;
      4'd4:    return 7'h66;
      4'd5:    return 7'h6D;
      4'd6:    return 7'h7D;
      4'd7:    return 7'h07;
      4'd8:    return 7'h7F;
      4'd9:    return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcd_tick_gen.sv
module bcd_tick_gen #(
  parameter int unsigned RATIO = 6_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (RATIO <= 1) begin : g_pass
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int unsigned CNT_W = $clog2(RATIO);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    logic [CNT_W-1:0] phase_q;
    logic             wrap;

    assign wrap   = (phase_q == LAST);
    assign tick_o = wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   phase_q <= '0;
      else if (wrap) phase_q <= '0;
      else           phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcd_step_calc.sv
module bcd_step_calc
  import bcd_disp_pkg::*;
(
  input  bcd_t cur_i,
  input  bcd_t step_i,
  input  logic dir_i,
  input  bcd_t load_val_i,
  output bcd_t cnt_nxt_o,
  output bcd_t load_nxt_o
);
  bcd_t  step_eff;
  wide_t up_sum;
  wide_t dn_sum;

  assign step_eff   = fold_radix({1'b0, step_i});
  assign up_sum     = {1'b0, cur_i} + {1'b0, step_eff};
  assign dn_sum     = {1'b0, cur_i} + wide_t'(RADIX) - {1'b0, step_eff};
  assign cnt_nxt_o  = (dir_e'(dir_i) == DIR_DOWN) ? fold_radix(dn_sum) : fold_radix(up_sum);
  assign load_nxt_o = fold_radix({1'b0, load_val_i});
endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
  import bcd_disp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic tick_i,
  input  bcd_t load_nxt_i,
  input  bcd_t cnt_nxt_i,
  output bcd_t digit_o
);
  logic arst_n;
  bcd_t digit_q;

  // chip reset and level clear share the async path
  assign arst_n = rst_ni & ~clr_i;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)     digit_q <= '0;
    else if (load_i) digit_q <= load_nxt_i;
    else if (tick_i) digit_q <= cnt_nxt_i;
  end

  assign digit_o = digit_q;
endmodule

// File: rtl/bcd_seg_enc.sv
module bcd_seg_enc
  import bcd_disp_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_o
);
  assign seg_o = glyph(digit_i);
endmodule

// File: rtl/bcd_disp_counter.sv
module bcd_disp_counter
  import bcd_disp_pkg::*;
#(
  parameter int unsigned DIV_RATIO = 6_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [3:0] load_val_i,
  input  logic       dir_i,
  input  logic [3:0] step_i,
  output logic [3:0] digit_o,
  output logic [6:0] seg_o
);
  logic tick_w;
  bcd_t cnt_nxt;
  bcd_t load_nxt;
  bcd_t digit_q;

  bcd_tick_gen #(.RATIO(DIV_RATIO)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  bcd_step_calc i_calc (
    .cur_i     (digit_q),
    .step_i    (step_i),
    .dir_i     (dir_i),
    .load_val_i(load_val_i),
    .cnt_nxt_o (cnt_nxt),
    .load_nxt_o(load_nxt)
  );

  bcd_digit_reg i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .load_i    (load_i),
    .tick_i    (tick_w),
    .load_nxt_i(load_nxt),
    .cnt_nxt_i (cnt_nxt),
    .digit_o   (digit_q)
  );

  bcd_seg_enc i_seg (
    .digit_i(digit_q),
    .seg_o  (seg_o)
  );

  assign digit_o = digit_q;
endmodule

// File: rtl/bcd_disp_counter_chk.sv
module bcd_disp_counter_chk #(
  parameter int unsigned DIV_RATIO = 6_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       load_i,
  input logic [3:0] load_val_i,
  input logic       dir_i,
  input logic [3:0] step_i,
  input logic       tick_i,
  input logic [3:0] digit_o,
  input logic [6:0] seg_o
);
  localparam int unsigned GAP_W = $clog2(DIV_RATIO + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(DIV_RATIO - 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_i) gap_q <= '0;
    else             gap_q <= gap_q + 1'b1;
  end

  a_r1_tick_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> gap_q == GAP_LAST);

  a_r1_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !clr_i) |=> (clr_i || $stable(digit_o)));

  a_r2_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clr_i && !dir_i && step_i == 4'd1 && digit_o == 4'd9)
      |=> (clr_i || digit_o == 4'd0));

  a_r3_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clr_i && dir_i && step_i == 4'd1 && digit_o == 4'd0)
      |=> (clr_i || digit_o == 4'd9));

  a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> digit_o == 4'd0);

  a_r6_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (clr_i ||
      digit_o == (($past(load_val_i) > 4'd9) ? $past(load_val_i) - 4'd10 : $past(load_val_i))));

  a_r8_seg_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_o == 4'd1) |-> $countones(seg_o) == 2);

  a_r9_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> digit_o == 4'd0);

  a_r10_legal_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_o <= 4'd9);
endmodule

bind bcd_disp_counter bcd_disp_counter_chk #(.DIV_RATIO(DIV_RATIO)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .dir_i     (dir_i),
  .step_i    (step_i),
  .tick_i    (tick_w),
  .digit_o   (digit_o),
  .seg_o     (seg_o)
);

// File: tb/test_bcd_disp_counter.sv
`timescale 1ns/1ps
module test_bcd_disp_counter;
  localparam int DIV = 4;
  localparam int WD_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load = 1'b0;
  logic [3:0] load_val = '0;
  logic       dir = 1'b0;
  logic [3:0] step = 4'd1;
  logic [3:0] digit;
  logic [6:0] seg;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  string cur_req = "R9";

  typedef struct { logic [3:0] d; logic [6:0] s; string tag; } exp_t;
  exp_t sb_q[$];

  int m_digit = 0;
  int m_phase = 0;

  always #4 clk = ~clk;

  bcd_disp_counter #(.DIV_RATIO(DIV)) i_bcd_disp_counter (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_i(load),
    .load_val_i(load_val), .dir_i(dir), .step_i(step),
    .digit_o(digit), .seg_o(seg)
  );

  // R8 glyph table
  function automatic logic [6:0] exp_seg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // reference model: R1 R2 R3 R4 R6 R7 R9
  always @(posedge clk) begin
    bit tk;
    if (!rst_n) begin
      m_phase = 0; m_digit = 0;
    end else begin
      tk = (m_phase == DIV - 1);
      m_phase = tk ? 0 : m_phase + 1;
      if (clr) m_digit = 0;
      else if (load) m_digit = int'(load_val) % 10;
      else if (tk) begin
        if (dir) m_digit = (m_digit + 10 - int'(step) % 10) % 10;
        else     m_digit = (m_digit + int'(step) % 10) % 10;
      end
    end
  end

  // driver-side prediction pushed each cycle; clear acts on the level (R5)
  always @(negedge clk) if (mon_en) begin
    exp_t e;
    int d;
    d = (!rst_n || clr) ? 0 : m_digit;
    e.d = 4'(d); e.s = exp_seg(d); e.tag = cur_req;
    sb_q.push_back(e);
  end

  // monitor
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (digit !== e.d || seg !== e.s) begin
        failures++;
        $display("FAIL %s/R8 digit=%0d seg=%02h expected digit=%0d seg=%02h",
                 e.tag, digit, seg, e.d, e.s);
      end
      if (digit > 4'd9) begin // R10
        checks++; failures++;
        $display("FAIL R10 digit=%0d expected <=9", digit);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic direct(string tag, logic [3:0] exp_d);
    checks++;
    if (digit !== exp_d) begin
      failures++;
      $display("FAIL %s digit=%0d expected %0d", tag, digit, exp_d);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog digit=%0d expected run to complete", digit);
      summary();
    end
  end

  initial begin
    mon_en = 1'b1;
    cur_req = "R9";
    cyc(3);
    direct("R9", 4'd0);
    rst_n = 1'b1;
    cur_req = "R1"; cyc(3 * DIV + 1);
    cur_req = "R2"; cyc(12 * DIV);
    cur_req = "R3"; dir = 1'b1; cyc(14 * DIV);
    cur_req = "R4"; dir = 1'b0; step = 4'd3; cyc(8 * DIV);
    step = 4'd13; cyc(5 * DIV);
    dir = 1'b1; step = 4'd7; cyc(6 * DIV);
    step = 4'd10; cyc(3 * DIV);
    step = 4'd0; cyc(3 * DIV);
    cur_req = "R6"; step = 4'd1; dir = 1'b0;
    load_val = 4'd5; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
    direct("R6", 4'd5);
    load_val = 4'd2; load = 1'b1; cyc(2 * DIV); load = 1'b0; cyc(2 * DIV);
    cur_req = "R7";
    load_val = 4'd14; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
    load_val = 4'd15; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
    load_val = 4'd9;  load = 1'b1; cyc(1); load = 1'b0; cyc(2 * DIV);
    load_val = 4'd10; load = 1'b1; cyc(1); load = 1'b0; cyc(DIV);
    cur_req = "R5";
    load_val = 4'd7; load = 1'b1; cyc(1); load = 1'b0; cyc(1);
    clr = 1'b1; #1;
    direct("R5", 4'd0);
    load = 1'b1; cyc(3 * DIV);
    direct("R5", 4'd0);
    load = 1'b0; cyc(2 * DIV);
    clr = 1'b0; cyc(3 * DIV);
    cur_req = "R9";
    rst_n = 1'b0; cyc(2);
    direct("R9", 4'd0);
    rst_n = 1'b1; cyc(DIV - 1);
    direct("R9", 4'd0);
    cyc(1);
    direct("R9", 4'd1);
    cyc(2 * DIV);
    mon_en = 1'b0;
    cyc(2);
    done = 1'b1;
    summary();
  end
endmodule